// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in front of the two ALU inputs of a five-stage in-order integer pipeline. It decides whether each ALU operand comes from the register file or from a result that an older instruction has produced but not yet written back. It also drives the operand multiplexers that act on that decision. The older instruction is either the one now in the memory stage or the one now in the write-back stage.

For each operand, the block compares the execute-stage source register number with the destination register number of the memory-stage instruction and of the write-back-stage instruction. A result is bypassed only when its producer actually writes a register and its destination is not register zero. When both later stages hold a match, the memory-stage result wins, because it is the younger one. The two operands are decided independently of each other.

The block is purely combinational, so its selects and operands follow its inputs within the same cycle. The register file is still written in write-back; bypassing only shortens the path a value takes to the ALU. Stall detection for loads and the ALU itself are outside the block.

Top module: `fwd_unit`

## Requirements
- R1: `sel_a` is 2'b10 and `op_a` equals `mem_val` whenever `mem_wr` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_src_a`.
- R2: `sel_b` is 2'b10 and `op_b` equals `mem_val` whenever `mem_wr` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_src_b`.
- R3: An operand's select is 2'b01 and its value equals `wb_val` whenever `wb_wr` is 1, `wb_dst` is nonzero, `wb_dst` equals that operand's source, and the R1/R2 condition for that operand is false.
- R4: When the memory-stage and write-back-stage conditions both hold for the same operand, that operand takes the memory-stage value (select 2'b10).
- R5: A destination of register 0 is never bypassed. Such an operand's select is 2'b00 and its value is the register-file read value, unless the other stage matches with a nonzero destination.
- R6: A stage whose write flag (`mem_wr` or `wb_wr`) is 0 is never bypassed, even when its destination matches.
- R7: With no qualifying match, an operand's select is 2'b00 and its value equals its register-file read value (`rf_a` or `rf_b`).
- R8: A select output never takes the value 2'b11.
- R9: The outputs are a combinational function of the current inputs. They are valid in the same cycle the inputs are applied, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_W | First source register number of the execute-stage instruction |
| ex_src_b | input | REG_W | Second source register number of the execute-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_W | Memory-stage destination register number |
| mem_val | input | DATA_W | Memory-stage result value |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| wb_dst | input | REG_W | Write-back-stage destination register number |
| wb_val | input | DATA_W | Write-back-stage value |
| rf_a | input | DATA_W | Register-file read value for the first source |
| rf_b | input | DATA_W | Register-file read value for the second source |
| op_a | output | DATA_W | Selected first ALU operand |
| op_b | output | DATA_W | Selected second ALU operand |
| sel_a | output | 2 | First operand select: 00 register file, 10 memory stage, 01 write-back stage |
| sel_b | output | 2 | Second operand select, same encoding |

## Verification
The two bypass sources can both match the same operand in the same cycle. This happens when the memory stage and the write-back stage target the same destination register that the execute stage reads. The bench provokes this by sweeping every combination of a small set of register numbers, including register 0, over both sources and both destinations, with all four settings of the two write flags. It judges each case against an arithmetic model in which the memory-stage match is tested first. The expected select and operand value are checked for both operands, so a match on one operand must not disturb the other.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  ex_src_a,
  input  logic [REG_W-1:0]  ex_src_b,
  input  logic              mem_wr,
  input  logic [REG_W-1:0]  mem_dst,
  input  logic [DATA_W-1:0] mem_val,
  input  logic              wb_wr,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic [DATA_W-1:0] wb_val,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;

  logic mem_live, wb_live;
  logic mem_hit_a, mem_hit_b, wb_hit_a, wb_hit_b;

  assign mem_live = mem_wr && (mem_dst != '0);
  assign wb_live  = wb_wr  && (wb_dst  != '0);

  assign mem_hit_a = mem_live && (mem_dst == ex_src_a);
  assign mem_hit_b = mem_live && (mem_dst == ex_src_b);
  assign wb_hit_a  = wb_live  && (wb_dst  == ex_src_a);
  assign wb_hit_b  = wb_live  && (wb_dst  == ex_src_b);

  assign sel_a = mem_hit_a ? SEL_MEM : (wb_hit_a ? SEL_WB : SEL_RF);
  assign sel_b = mem_hit_b ? SEL_MEM : (wb_hit_b ? SEL_WB : SEL_RF);

  always_comb begin
    unique case (sel_a)
      SEL_MEM: op_a = mem_val;
      SEL_WB:  op_a = wb_val;
      default: op_a = rf_a;
    endcase
    unique case (sel_b)
      SEL_MEM: op_b = mem_val;
      SEL_WB:  op_b = wb_val;
      default: op_b = rf_b;
    endcase
  end

endmodule

module fwd_unit_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [REG_W-1:0]  ex_src_a,
  input logic [REG_W-1:0]  ex_src_b,
  input logic              mem_wr,
  input logic [REG_W-1:0]  mem_dst,
  input logic [DATA_W-1:0] mem_val,
  input logic              wb_wr,
  input logic [REG_W-1:0]  wb_dst,
  input logic [DATA_W-1:0] wb_val,
  input logic [DATA_W-1:0] rf_a,
  input logic [DATA_W-1:0] rf_b,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b
);

  always_comb begin
    // R8
    sel_a_legal_chk: assert (sel_a != 2'b11);
    // R8
    sel_b_legal_chk: assert (sel_b != 2'b11);
    // R1
    mem_a_qualified_chk: assert (sel_a != 2'b10 || (mem_wr && mem_dst != '0 && mem_dst == ex_src_a));
    // R2
    mem_b_qualified_chk: assert (sel_b != 2'b10 || (mem_wr && mem_dst != '0 && mem_dst == ex_src_b));
    // R3
    wb_a_qualified_chk: assert (sel_a != 2'b01 || (wb_wr && wb_dst != '0 && wb_dst == ex_src_a));
    // R3
    wb_b_qualified_chk: assert (sel_b != 2'b01 || (wb_wr && wb_dst != '0 && wb_dst == ex_src_b));
    // R4
    mem_wins_a_chk: assert (!(mem_wr && mem_dst != '0 && mem_dst == ex_src_a) || sel_a == 2'b10);
    // R4
    mem_wins_b_chk: assert (!(mem_wr && mem_dst != '0 && mem_dst == ex_src_b) || sel_b == 2'b10);
    // R7
    rf_a_value_chk: assert (sel_a != 2'b00 || op_a == rf_a);
    // R7
    rf_b_value_chk: assert (sel_b != 2'b00 || op_b == rf_b);
  end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_fwd_unit_chk (.*);

// File: tb/fwd_unit_bench.sv
`timescale 1ns/1ps
module fwd_unit_bench;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [REG_W-1:0]  ex_src_a, ex_src_b, mem_dst, wb_dst;
  logic              mem_wr, wb_wr;
  logic [DATA_W-1:0] mem_val, wb_val, rf_a, rf_b;
  logic [DATA_W-1:0] op_a, op_b;
  logic [1:0]        sel_a, sel_b;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  fwd_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) u_fwd_unit (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .mem_wr(mem_wr), .mem_dst(mem_dst), .mem_val(mem_val),
    .wb_wr(wb_wr), .wb_dst(wb_dst), .wb_val(wb_val),
    .rf_a(rf_a), .rf_b(rf_b),
    .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b)
  );

  function automatic string tag_of(logic [REG_W-1:0] src, bit first);
    bit mm = (mem_dst == src);
    bit wm = (wb_dst == src);
    if (mm && wm && mem_wr && wb_wr && src != 0) return "R4";
    if ((mm && mem_dst == 0) || (wm && wb_dst == 0)) return "R5";
    if ((mm && !mem_wr) || (wm && !wb_wr)) return "R6";
    if (mm && mem_wr) return first ? "R1" : "R2";
    if (wm && wb_wr) return "R3";
    return "R7";
  endfunction

  task automatic check_op(string tag, string nm, logic [1:0] s_act, logic [1:0] s_exp,
                          logic [DATA_W-1:0] v_act, logic [DATA_W-1:0] v_exp);
    checks++;
    if (s_act !== s_exp || v_act !== v_exp || s_act === 2'b11) begin
      errors++;
      $display("FAIL %s (R8/R9 same-cycle) %s: sel=%b val=%h expected sel=%b val=%h",
               tag, nm, s_act, v_act, s_exp, v_exp);
    end
  endtask

  task automatic expect_one(logic [REG_W-1:0] src, logic [DATA_W-1:0] rf,
                            output logic [1:0] s, output logic [DATA_W-1:0] v);
    if (mem_wr && mem_dst != 0 && mem_dst == src) begin s = 2'b10; v = mem_val; end
    else if (wb_wr && wb_dst != 0 && wb_dst == src) begin s = 2'b01; v = wb_val; end
    else begin s = 2'b00; v = rf; end
  endtask

  task automatic apply_and_check(logic [REG_W-1:0] a, logic [REG_W-1:0] b,
                                 logic [REG_W-1:0] md, logic [REG_W-1:0] wd,
                                 logic mw, logic ww);
    logic [1:0] se_a, se_b;
    logic [DATA_W-1:0] ve_a, ve_b;
    @(negedge clk);
    ex_src_a = a; ex_src_b = b; mem_dst = md; wb_dst = wd; mem_wr = mw; wb_wr = ww;
    mem_val = 32'hA500_0000 | (32'(md) << 8) | 32'(wd);
    wb_val  = 32'h5B00_0000 | (32'(wd) << 8) | 32'(md);
    rf_a    = 32'h1100_0000 | 32'(a);
    rf_b    = 32'h2200_0000 | 32'(b);
    #1;
    expect_one(a, rf_a, se_a, ve_a);
    expect_one(b, rf_b, se_b, ve_b);
    check_op(tag_of(a, 1'b1), "op_a", sel_a, se_a, op_a, ve_a);
    check_op(tag_of(b, 1'b0), "op_b", sel_b, se_b, op_b, ve_b);
  endtask

  initial begin
    ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
    mem_wr = 1'b0; wb_wr = 1'b0;
    mem_val = '0; wb_val = '0; rf_a = 32'hCAFE_0001; rf_b = 32'hCAFE_0002;
    #1;
    // R7: idle inputs select the register file
    check_op("R7", "idle_a", sel_a, 2'b00, op_a, 32'hCAFE_0001);
    check_op("R7", "idle_b", sel_b, 2'b00, op_b, 32'hCAFE_0002);

    // Near-exhaustive sweep covering R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int md = 0; md < 4; md++)
          for (int wd = 0; wd < 4; wd++)
            for (int w = 0; w < 4; w++)
              apply_and_check(REG_W'(a), REG_W'(b), REG_W'(md), REG_W'(wd), w[1], w[0]);

    // Top register number, R4 both stages on register 31
    apply_and_check(5'd31, 5'd31, 5'd31, 5'd31, 1'b1, 1'b1);
    // R3 with a high register only in write-back
    apply_and_check(5'd30, 5'd2, 5'd29, 5'd30, 1'b1, 1'b1);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end else if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule